// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming frame, whether the receive path should keep it. The destination address arrives one byte per cycle as the first six bytes of the frame, together with the frame's total length. From these and a small set of configuration inputs the block produces a registered verdict: accept or reject, plus a group flag that marks an accepted broadcast or multicast frame so the status logic can record it. Writing the frame to buffers and appending a CRC are handled elsewhere.

The block keeps two pieces of filter state. The first is the station address, written whole through a load strobe. The second is a 64-bit multicast hash table, built from a list of group addresses. A list load first wipes the table. It then takes the entry count as the list length in bytes divided by six, limited to 64 entries. Each address is run through the Ethernet CRC-32 and one table bit is set per address. A multicast frame is matched by hashing its destination address the same way, in parallel with the incoming bytes.

The list loader has three states. `ML_IDLE` goes to `ML_CLEAR` on a start pulse. `ML_CLEAR` wipes the table and then goes to `ML_LOAD`, or straight back to `ML_IDLE` when the entry count is zero. `ML_LOAD` takes address bytes and returns to `ML_IDLE` when the sixth byte of the last counted entry arrives. The frame checker has two states. `FC_IDLE` goes to `FC_COLLECT` on a start-of-frame byte. `FC_COLLECT` returns to `FC_IDLE` on the sixth address byte, at which point the verdict is registered. A new start-of-frame byte in `FC_COLLECT` restarts collection.

Top module: `rx_addr_filter`

## Requirements
- R1: While `rx_suspended_i` is 1 or `link_up_i` is 0 during the sixth address byte, the verdict is reject, whatever else is set.
- R2: A frame whose `fr_len_i` is below `min_len_i` is rejected, even in promiscuous mode. A length equal to `min_len_i` passes this check.
- R3: When `rx_mode_i` bit 0 (promiscuous) is 1, every frame that passes R1 and R2 is accepted, with the group flag 0.
- R4: An all-ones destination is broadcast. It is rejected when `rx_mode_i` bit 1 (broadcast disable) is 1; otherwise it is accepted with the group flag 1.
- R5: A destination whose first byte has bit 0 set, and that is not broadcast, is multicast. It is rejected unless `mc_mode_i` bit 5 is 1. If that bit is 1, it is accepted with the group flag 1 only when the table bit at index CRC bits 7:2 of its address is set.
- R6: Any other destination is accepted, with the group flag 0, only when all six bytes equal the stored station address. Byte k of an address is bits 8k+7:8k, and byte 0 is sent first.
- R7: A list load clears the whole table, takes min(`ml_len_i`/6, 64) entries, and sets one table bit per entry. `ml_busy_o` is 1 from the cycle after the start pulse until the load completes. Bytes that arrive while the loader is idle are ignored.
- R8: The hash is the reflected CRC-32: polynomial 0xEDB88320, preset to all ones, bits taken least significant first, over the six address bytes, with no final inversion.
- R9: `dec_valid_o` is 1 for exactly the one cycle after the sixth address byte. The verdict is registered at that point and holds until the next decision. After reset the verdict, the group flag and `dec_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sta_load_i | input | 1 | Write `sta_addr_i` into the station address |
| sta_addr_i | input | 48 | Station address, byte 0 in bits 7:0 |
| ml_start_i | input | 1 | Start a multicast list load |
| ml_len_i | input | 16 | List length in bytes, sampled with the start pulse |
| ml_byte_valid_i | input | 1 | List byte strobe |
| ml_byte_i | input | 8 | List byte |
| ml_busy_o | output | 1 | List load in progress |
| rx_mode_i | input | 8 | Bit 0 promiscuous, bit 1 broadcast disable |
| mc_mode_i | input | 8 | Bit 5 multicast accept enable |
| min_len_i | input | 8 | Minimum accepted frame length |
| rx_suspended_i | input | 1 | Receiver suspended |
| link_up_i | input | 1 | Link is up |
| fr_valid_i | input | 1 | Destination byte strobe |
| fr_sof_i | input | 1 | Marks the first destination byte |
| fr_byte_i | input | 8 | Destination byte |
| fr_len_i | input | 16 | Frame length, valid with the sixth byte |
| dec_valid_o | output | 1 | Verdict strobe |
| accept_o | output | 1 | Frame accepted |
| group_o | output | 1 | Accepted broadcast or multicast frame |

## Verification
The bench uses the default parameters: six address bytes, a 6-bit hash, a 64-entry cap and 16-bit lengths. With these values the cap is reached with a 420-byte list whose last six entries carry an address that hashes to a different bit, so an uncapped loader would be caught by that address being accepted. The small hash width also means the bench can find addresses with distinct hashes by short search, computing each hash from the R8 definition. This covers matching, non-matching and stale entries after a reload or an empty load.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ML_IDLE,
        ML_CLEAR,
        ML_LOAD
    } ml_state_t;

    typedef enum logic {
        FC_IDLE,
        FC_COLLECT
    } fc_state_t;

    typedef struct packed {
        logic accept;
        logic group;
    } verdict_t;
endpackage

// File: rtl/rxf_crc_step.sv
module rxf_crc_step
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [31:0]       crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [31:0]       crc_o
);
    logic [31:0] stage [0:DATA_W];

    assign stage[0] = crc_i;

    // one reflected shift per data bit, lsb first
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            logic fb;
            assign fb = stage[b][0] ^ data_i[b];
            assign stage[b+1] = {1'b0, stage[b][31:1]} ^ (fb ? CRC_POLY : 32'h0);
        end
    endgenerate

    assign crc_o = stage[DATA_W];
endmodule

// File: rtl/rxf_hash_loader.sv
module rxf_hash_loader
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int HASH_BITS   = 6,
    parameter int MAX_ENTRIES = 64,
    parameter int LEN_W       = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [LEN_W-1:0]            len_i,
    input  logic                        byte_valid_i,
    input  logic [7:0]                  byte_i,
    output logic                        busy_o,
    output logic [(1<<HASH_BITS)-1:0]   table_o
);
    localparam int TABLE_SIZE = 1 << HASH_BITS;
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1);
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);

    ml_state_t              state_q, state_d;
    logic [CNT_W-1:0]       target_q, ent_q, target_d;
    logic [IDX_W-1:0]       bidx_q;
    logic [31:0]            crc_q, crc_next;
    logic [TABLE_SIZE-1:0]  table_q;
    logic [LEN_W-1:0]       raw_cnt;
    logic                   entry_done, list_done;
    logic [HASH_BITS-1:0]   hash;

    rxf_crc_step #(.DATA_W(8)) u_crc (
        .crc_i  (crc_q),
        .data_i (byte_i),
        .crc_o  (crc_next)
    );

    assign raw_cnt    = LEN_W'(len_i / LEN_W'(ADDR_BYTES));
    assign target_d   = (raw_cnt > LEN_W'(MAX_ENTRIES)) ? CNT_W'(MAX_ENTRIES)
                                                        : CNT_W'(raw_cnt);
    assign hash       = crc_next[HASH_BITS+1:2];
    assign entry_done = byte_valid_i && (bidx_q == IDX_W'(ADDR_BYTES - 1));
    assign list_done  = entry_done && (CNT_W'(ent_q + 1'b1) == target_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ML_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ML_IDLE:  if (start_i) state_d = ML_CLEAR;
            ML_CLEAR: state_d = (target_q == '0) ? ML_IDLE : ML_LOAD;
            ML_LOAD:  if (list_done) state_d = ML_IDLE;
            default:  state_d = ML_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            ent_q    <= '0;
            bidx_q   <= '0;
            crc_q    <= CRC_PRESET;
            table_q  <= '0;
        end else begin
            unique case (state_q)
                ML_IDLE: begin
                    if (start_i) begin
                        target_q <= target_d;
                        ent_q    <= '0;
                        bidx_q   <= '0;
                        crc_q    <= CRC_PRESET;
                    end
                end
                ML_CLEAR: table_q <= '0;
                ML_LOAD: begin
                    if (byte_valid_i) begin
                        if (entry_done) begin
                            table_q[hash] <= 1'b1;
                            ent_q         <= CNT_W'(ent_q + 1'b1);
                            bidx_q        <= '0;
                            crc_q         <= CRC_PRESET;
                        end else begin
                            bidx_q <= IDX_W'(bidx_q + 1'b1);
                            crc_q  <= crc_next;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o  = (state_q != ML_IDLE);
        table_o = table_q;
    end

    // R7
    clear_wipes_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ML_CLEAR) |=> (table_q == '0));
    // R7
    entry_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_q <= target_q) && (target_q <= CNT_W'(MAX_ENTRIES)));
    // R7
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/rxf_frame_check.sv
module rxf_frame_check
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int LEN_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         byte_valid_i,
    input  logic                         sof_i,
    input  logic [7:0]                   byte_i,
    input  logic [LEN_W-1:0]             len_i,
    input  logic [7:0]                   min_len_i,
    input  logic [7:0]                   rx_mode_i,
    input  logic [7:0]                   mc_mode_i,
    input  logic                         rx_suspended_i,
    input  logic                         link_up_i,
    input  logic [8*ADDR_BYTES-1:0]      station_i,
    input  logic [(1<<HASH_BITS)-1:0]    table_i,
    output logic                         dec_valid_o,
    output logic                         accept_o,
    output logic                         group_o
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int IDX_W  = $clog2(ADDR_BYTES + 1);

    fc_state_t            state_q, state_d;
    logic [IDX_W-1:0]     idx_q, widx;
    logic [ADDR_W-1:0]    addr_q, dest;
    logic [31:0]          crc_q, crc_in, crc_next;
    logic                 take, last_byte;
    logic                 gate_ok, len_ok, is_bcast, is_mcast;
    logic [HASH_BITS-1:0] hash;
    verdict_t             verdict, verdict_q;
    logic                 dec_valid_q;
    logic                 unused_mode_bits;

    assign unused_mode_bits = ^{rx_mode_i[7:2], mc_mode_i[7:6], mc_mode_i[4:0]};

    assign crc_in = sof_i ? CRC_PRESET : crc_q;

    rxf_crc_step #(.DATA_W(8)) u_crc (
        .crc_i  (crc_in),
        .data_i (byte_i),
        .crc_o  (crc_next)
    );

    assign take      = byte_valid_i && (sof_i || state_q == FC_COLLECT);
    assign widx      = sof_i ? '0 : idx_q;
    assign last_byte = take && (widx == IDX_W'(ADDR_BYTES - 1));

    // destination as it stands once the current byte is included
    always_comb begin
        dest = addr_q;
        dest[8*(ADDR_BYTES-1) +: 8] = byte_i;
    end

    assign gate_ok  = !rx_suspended_i && link_up_i;
    assign len_ok   = (len_i >= LEN_W'(min_len_i));
    assign is_bcast = &dest;
    assign is_mcast = dest[0];
    assign hash     = crc_next[HASH_BITS+1:2];

    always_comb begin
        verdict = '0;
        if (gate_ok && len_ok) begin
            if (rx_mode_i[0]) begin
                verdict.accept = 1'b1;
            end else if (is_bcast) begin
                if (!rx_mode_i[1]) verdict = '{accept: 1'b1, group: 1'b1};
            end else if (is_mcast) begin
                if (mc_mode_i[5] && table_i[hash])
                    verdict = '{accept: 1'b1, group: 1'b1};
            end else if (dest == station_i) begin
                verdict.accept = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FC_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_IDLE:    if (byte_valid_i && sof_i)
                            state_d = last_byte ? FC_IDLE : FC_COLLECT;
            FC_COLLECT: if (last_byte) state_d = FC_IDLE;
            default:    state_d = FC_IDLE;
        endcase
    end

    // address and crc collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            addr_q <= '0;
            crc_q  <= CRC_PRESET;
        end else if (take) begin
            addr_q[8*widx +: 8] <= byte_i;
            crc_q               <= crc_next;
            idx_q               <= IDX_W'(widx + 1'b1);
        end
    end

    // registered verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid_q <= 1'b0;
            verdict_q   <= '0;
        end else begin
            dec_valid_q <= last_byte;
            if (last_byte) verdict_q <= verdict;
        end
    end

    always_comb begin
        dec_valid_o = dec_valid_q;
        accept_o    = verdict_q.accept;
        group_o     = verdict_q.group;
    end

    // R9
    verdict_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |=> dec_valid_o);
    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> $past(last_byte));
    // R1
    gate_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && (rx_suspended_i || !link_up_i)) |=> !accept_o);
    // R2
    short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && (len_i < LEN_W'(min_len_i))) |=> !accept_o);
    // R3
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && gate_ok && len_ok && rx_mode_i[0]) |=> (accept_o && !group_o));
    // R4
    bcast_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && is_bcast && !rx_mode_i[0] && rx_mode_i[1]) |=> !accept_o);
    // R5
    group_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        group_o |-> accept_o);
    // R6
    unicast_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && !rx_mode_i[0] && !is_mcast && (dest != station_i)) |=> !accept_o);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int HASH_BITS   = 6,
    parameter int MAX_ENTRIES = 64,
    parameter int LEN_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sta_load_i,
    input  logic [8*ADDR_BYTES-1:0] sta_addr_i,
    input  logic                    ml_start_i,
    input  logic [LEN_W-1:0]        ml_len_i,
    input  logic                    ml_byte_valid_i,
    input  logic [7:0]              ml_byte_i,
    output logic                    ml_busy_o,
    input  logic [7:0]              rx_mode_i,
    input  logic [7:0]              mc_mode_i,
    input  logic [7:0]              min_len_i,
    input  logic                    rx_suspended_i,
    input  logic                    link_up_i,
    input  logic                    fr_valid_i,
    input  logic                    fr_sof_i,
    input  logic [7:0]              fr_byte_i,
    input  logic [LEN_W-1:0]        fr_len_i,
    output logic                    dec_valid_o,
    output logic                    accept_o,
    output logic                    group_o
);
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int TABLE_SIZE = 1 << HASH_BITS;

    logic [ADDR_W-1:0]     station_q;
    logic [TABLE_SIZE-1:0] hash_table;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          station_q <= '0;
        else if (sta_load_i) station_q <= sta_addr_i;
    end

    rxf_hash_loader #(
        .ADDR_BYTES  (ADDR_BYTES),
        .HASH_BITS   (HASH_BITS),
        .MAX_ENTRIES (MAX_ENTRIES),
        .LEN_W       (LEN_W)
    ) u_loader (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (ml_start_i),
        .len_i        (ml_len_i),
        .byte_valid_i (ml_byte_valid_i),
        .byte_i       (ml_byte_i),
        .busy_o       (ml_busy_o),
        .table_o      (hash_table)
    );

    rxf_frame_check #(
        .ADDR_BYTES (ADDR_BYTES),
        .HASH_BITS  (HASH_BITS),
        .LEN_W      (LEN_W)
    ) u_check (
        .clk            (clk),
        .rst_n          (rst_n),
        .byte_valid_i   (fr_valid_i),
        .sof_i          (fr_sof_i),
        .byte_i         (fr_byte_i),
        .len_i          (fr_len_i),
        .min_len_i      (min_len_i),
        .rx_mode_i      (rx_mode_i),
        .mc_mode_i      (mc_mode_i),
        .rx_suspended_i (rx_suspended_i),
        .link_up_i      (link_up_i),
        .station_i      (station_q),
        .table_i        (hash_table),
        .dec_valid_o    (dec_valid_o),
        .accept_o       (accept_o),
        .group_o        (group_o)
    );
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sta_load, ml_start, ml_byte_valid, ml_busy;
    logic [47:0] sta_addr;
    logic [15:0] ml_len, fr_len;
    logic [7:0]  ml_byte, rx_mode, mc_mode, min_len, fr_byte;
    logic        rx_susp, link_up, fr_valid, fr_sof;
    logic        dec_valid, accept, group;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .sta_load_i(sta_load), .sta_addr_i(sta_addr),
        .ml_start_i(ml_start), .ml_len_i(ml_len),
        .ml_byte_valid_i(ml_byte_valid), .ml_byte_i(ml_byte), .ml_busy_o(ml_busy),
        .rx_mode_i(rx_mode), .mc_mode_i(mc_mode), .min_len_i(min_len),
        .rx_suspended_i(rx_susp), .link_up_i(link_up),
        .fr_valid_i(fr_valid), .fr_sof_i(fr_sof), .fr_byte_i(fr_byte), .fr_len_i(fr_len),
        .dec_valid_o(dec_valid), .accept_o(accept), .group_o(group)
    );

    localparam logic [47:0] STA   = 48'h6655_4433_2210;
    localparam logic [47:0] OTHER = 48'h6655_4433_2310;
    localparam logic [47:0] BC    = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] GRP   = 48'h6655_4433_2211;

    typedef struct packed {
        logic [47:0] dest;
        logic [15:0] len;
        logic [7:0]  minl;
        logic [7:0]  rxm;
        logic [7:0]  mcm;
        logic        susp;
        logic        link;
        logic        acc;
        logic        grp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{STA,   16'd64, 8'd60, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6}, // R6 match
        '{OTHER, 16'd64, 8'd60, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd6}, // R6 mismatch
        '{BC,    16'd64, 8'd60, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'd4}, // R4 accept
        '{BC,    16'd64, 8'd60, 8'h02, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4}, // R4 disabled
        '{STA,   16'd64, 8'd60, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1}, // R1 suspended
        '{STA,   16'd64, 8'd60, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1}, // R1 link down
        '{STA,   16'd59, 8'd60, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2}, // R2 one short
        '{STA,   16'd60, 8'd60, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'd2}, // R2 equal
        '{OTHER, 16'd64, 8'd60, 8'h01, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3}, // R3 any unicast
        '{BC,    16'd64, 8'd60, 8'h03, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3}, // R3 over bcast disable
        '{OTHER, 16'd64, 8'd60, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1}, // R1 over promisc
        '{GRP,   16'd64, 8'd60, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5}, // R5 mc disabled
        '{GRP,   16'd64, 8'd60, 8'h00, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5}, // R5 empty table
        '{OTHER, 16'd10, 8'd60, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2}  // R2 over promisc
    };

    // R8 hash, computed from the definition
    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb;
            fb = c[0] ^ a[i];
            c  = (c >> 1) ^ (fb ? 32'hEDB8_8320 : 32'h0);
        end
        return c[7:2];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [47:0] d, input logic [15:0] len,
                              input logic [7:0] minl, input logic [7:0] rxm,
                              input logic [7:0] mcm, input logic susp, input logic link,
                              output logic v, output logic a, output logic g,
                              output logic early);
        rx_mode = rxm; mc_mode = mcm; min_len = minl; rx_susp = susp; link_up = link;
        early = 1'b0;
        for (int b = 0; b < 6; b++) begin
            fr_valid = 1'b1;
            fr_sof   = (b == 0);
            fr_byte  = d[8*b +: 8];
            fr_len   = len;
            @(negedge clk);
            if (b < 5) early = early | dec_valid;
        end
        fr_valid = 1'b0;
        fr_sof   = 1'b0;
        v = dec_valid; a = accept; g = group;
    endtask

    task automatic load_list(input int len, input int n1, input int n2,
                             input logic [47:0] a1, input logic [47:0] a2);
        ml_start = 1'b1;
        ml_len   = 16'(len);
        @(negedge clk);
        ml_start = 1'b0;
        @(negedge clk);
        for (int e = 0; e < n1 + n2; e++) begin
            logic [47:0] cur;
            cur = (e < n1) ? a1 : a2;
            for (int b = 0; b < 6; b++) begin
                ml_byte_valid = 1'b1;
                ml_byte       = cur[8*b +: 8];
                @(negedge clk);
            end
        end
        ml_byte_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // expects a multicast frame with the enable bit set
    task automatic mc_expect(input logic [47:0] d, input logic exp_acc, input string tag);
        logic v, a, g, e;
        send_frame(d, 16'd64, 8'd60, 8'h00, 8'h20, 1'b0, 1'b1, v, a, g, e);
        chk(v == 1'b1 && a == exp_acc && g == exp_acc, tag, {29'b0, v, a, g}, {29'b0, 1'b1, exp_acc, exp_acc});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic v, a, g, e;
        logic [47:0] m1, m2, m3;
        rst_n = 1'b0;
        sta_load = 0; sta_addr = '0; ml_start = 0; ml_len = '0; ml_byte_valid = 0; ml_byte = '0;
        rx_mode = '0; mc_mode = '0; min_len = '0; rx_susp = 0; link_up = 1;
        fr_valid = 0; fr_sof = 0; fr_byte = '0; fr_len = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(dec_valid == 0 && accept == 0 && group == 0, "R9 reset verdict",
            {29'b0, dec_valid, accept, group}, 32'h0);
        chk(ml_busy == 0, "R7 reset busy", {31'b0, ml_busy}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        sta_load = 1'b1; sta_addr = STA;
        @(negedge clk);
        sta_load = 1'b0;

        for (int i = 0; i < NV; i++) begin
            send_frame(VECS[i].dest, VECS[i].len, VECS[i].minl, VECS[i].rxm, VECS[i].mcm,
                       VECS[i].susp, VECS[i].link, v, a, g, e);
            checks++;
            if (!(v == 1'b1 && e == 1'b0 && a == VECS[i].acc && g == VECS[i].grp)) begin
                fails++;
                $display("FAIL R%0d vector %0d: actual v=%0b early=%0b acc=%0b grp=%0b expected v=1 early=0 acc=%0b grp=%0b",
                         VECS[i].req, i, v, e, a, g, VECS[i].acc, VECS[i].grp);
            end
        end

        // R9 strobe lasts one cycle, verdict holds
        @(negedge clk);
        chk(dec_valid == 0 && accept == VECS[NV-1].acc, "R9 strobe width",
            {30'b0, dec_valid, accept}, {31'b0, VECS[NV-1].acc});

        // pick three group addresses with distinct hashes (R8)
        m1 = 48'h0000_5E00_0001;
        m2 = m1;
        for (int k = 1; k < 256; k++) begin
            m2 = {m1[47:16], 8'(k), m1[7:0]};
            if (ref_hash(m2) != ref_hash(m1)) break;
        end
        m3 = m1;
        for (int k = 1; k < 256; k++) begin
            m3 = {m1[47:40], 8'(k), m1[31:0]};
            if (ref_hash(m3) != ref_hash(m1) && ref_hash(m3) != ref_hash(m2)) break;
        end

        // R5 and R8: single entry list
        load_list(6, 1, 0, m1, m1);
        chk(ml_busy == 0, "R7 busy after load", {31'b0, ml_busy}, 32'h0);
        mc_expect(m1, 1'b1, "R5 listed group accepted");
        mc_expect(m3, 1'b0, "R8 unlisted hash rejected");
        send_frame(m1, 16'd64, 8'd60, 8'h00, 8'h00, 1'b0, 1'b1, v, a, g, e);
        chk(v && !a && !g, "R5 enable bit clear", {29'b0, v, a, g}, 32'h4);

        // R7 cap: 70 entries requested, the 6 beyond 64 carry m2
        load_list(420, 64, 6, m1, m2);
        mc_expect(m1, 1'b1, "R7 capped list keeps first entries");
        mc_expect(m2, 1'b0, "R7 entries beyond cap ignored");

        // R7 reload clears older bits
        load_list(12, 0, 2, m1, m2);
        mc_expect(m1, 1'b0, "R7 reload clears table");
        mc_expect(m2, 1'b1, "R7 reload sets new bit");

        // R7 length not a multiple of 6 rounds down: 11 bytes -> 1 entry
        load_list(11, 1, 0, m3, m3);
        mc_expect(m3, 1'b1, "R7 rounded count loads one entry");
        mc_expect(m2, 1'b0, "R7 rounded load cleared old entry");

        // R7 empty list only clears
        load_list(0, 0, 0, m1, m1);
        mc_expect(m3, 1'b0, "R7 empty list clears table");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule